// File: doc/BRIEF.md
# Lane Receive Elastic Buffer

This block sits between the clock recovered from one serial lane and the local receive clock. It accepts one 10-bit line symbol per recovered-clock cycle and delivers one symbol per local-clock cycle. The two clocks are nominally equal, but each may be off by up to 300 ppm, so the two rates can differ by up to 600 ppm. To absorb that drift, the buffer works on skip ordered sets, which are a comma symbol followed by skip symbols. It drops one skip symbol when the buffer runs too full and emits one skip symbol twice when it runs too empty. Every other symbol passes through unchanged.

Dropping happens on the write side, and the write side judges fill from its own write pointer and a Gray-coded copy of the read pointer. Repeating happens on the read side, and the read side judges fill from its own read pointer and a Gray-coded copy of the write pointer. Each pointer copy reaches the other domain after a register stage and a two-flop synchronizer. The fill thresholds are offset by that transfer lag, so the true fill sits near half of the 16 entries. Overflow and underflow are reported on sticky flags that only reset clears.

Top module: `rx_elastic_buf`

## Requirements
- R1: Every symbol that is neither a comma nor a skip symbol leaves the buffer in the order it was written, and none is lost, altered or duplicated. Comma symbols are also never dropped or repeated.
- R2: While reset is applied and just after it, `rd_valid`, `ovf_err` and `unf_err` are 0.
- R3: After reset, `rd_valid` stays 0 until the read-side fill reaches 5, which is DEPTH/2 minus the 3-cycle pointer transfer lag. With 4 symbols written nothing is output; with 5 symbols written, all 5 are output.
- R4: When the write-side fill is at least 13, the block drops one incoming skip symbol that directly follows a comma or a skip symbol. It drops at most one skip symbol per ordered set.
- R5: When the read-side fill is below 3 and the next symbol is a skip symbol that follows a comma or a skip symbol, the block outputs that skip symbol on two consecutive cycles. It does this at most once per ordered set.
- R6: When both clocks run at the same frequency, no skip symbol is dropped or repeated.
- R7: A symbol that arrives while the write-side fill is 16 is discarded and sets `ovf_err`. The flag stays set until reset.
- R8: Once reading has started, a read cycle with read-side fill 0 drives `rd_valid` low and sets `unf_err`. The flag stays set until reset.
- R9: The comma symbol is recognised as 10'b0011111010 or 10'b1100000101. The skip symbol is recognised as 10'b0011110100 or 10'b1100001011. Both running-disparity forms are treated alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Recovered receive clock (write side) |
| wrst_n | input | 1 | Asynchronous active-low reset for the write side |
| wr_valid | input | 1 | A symbol is presented on `wr_sym` this cycle |
| wr_sym | input | 10 | Incoming 10-bit line symbol |
| rclk | input | 1 | Local receive clock (read side) |
| rrst_n | input | 1 | Asynchronous active-low reset for the read side |
| rd_sym | output | 10 | Outgoing 10-bit line symbol |
| rd_valid | output | 1 | `rd_sym` holds a symbol this cycle |
| ovf_err | output | 1 | Sticky overflow flag, write clock domain |
| unf_err | output | 1 | Sticky underflow flag, read clock domain |

## Verification
A wrong fill estimate in either domain shows up at the ports within one ordered set. It appears as a skip run that is one symbol shorter or longer than the one written, or as a second change in the same set. If the estimate is far off, it appears as a sticky error flag a few tens of cycles later. A pointer that slips or a corrupted entry shows as a mismatch in the stream of non-skip symbols on the very next output. A wrong start level shows as output appearing after 4 symbols, or as no output after 5.

// File: rtl/rxeb_pkg.sv
package rxeb_pkg;
  localparam int SYM_W = 10;

  localparam logic [SYM_W-1:0] COMMA_NEG = 10'b0011111010;
  localparam logic [SYM_W-1:0] COMMA_POS = 10'b1100000101;
  localparam logic [SYM_W-1:0] SKIP_NEG  = 10'b0011110100;
  localparam logic [SYM_W-1:0] SKIP_POS  = 10'b1100001011;

  // R9: both disparity forms count
  function automatic logic sym_is_comma(input logic [SYM_W-1:0] s);
    return (s == COMMA_NEG) || (s == COMMA_POS);
  endfunction

  function automatic logic sym_is_skip(input logic [SYM_W-1:0] s);
    return (s == SKIP_NEG) || (s == SKIP_POS);
  endfunction
endpackage

// File: rtl/rxeb_rst_sync.sv
module rxeb_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= '0;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/rxeb_gray_sync.sv
module rxeb_gray_sync #(
  parameter int PW     = 5,
  parameter int STAGES = 2
) (
  input  logic          src_clk,
  input  logic          src_rst_n,
  input  logic [PW-1:0] src_bin,
  input  logic          dst_clk,
  input  logic          dst_rst_n,
  output logic [PW-1:0] dst_bin
);
  logic [PW-1:0]             gray_d, gray_q;
  logic [STAGES-1:0][PW-1:0] chain_q;

  assign gray_d = src_bin ^ (src_bin >> 1);

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) gray_q <= '0;
    else            gray_q <= gray_d;
  end

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      chain_q <= '0;
    end else begin
      for (int s = STAGES - 1; s > 0; s--) chain_q[s] <= chain_q[s-1];
      chain_q[0] <= gray_q;
    end
  end

  always_comb begin
    for (int i = 0; i < PW; i++) dst_bin[i] = ^(chain_q[STAGES-1] >> i);
  end
endmodule

// File: rtl/rxeb_wr_ctl.sv
module rxeb_wr_ctl
  import rxeb_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int HI_LVL = 13
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_vld,
  input  logic [SYM_W-1:0]         in_sym,
  input  logic [$clog2(DEPTH):0]   rptr_s,
  output logic [$clog2(DEPTH):0]   wptr,
  output logic                     we,
  output logic [$clog2(DEPTH)-1:0] waddr,
  output logic                     ovf
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0] wptr_q, wptr_d, wfill;
  logic          in_os_q, in_os_d, del_done_q, del_done_d, ovf_q, ovf_d;
  logic          is_skp, is_com, full, drop, push;

  assign is_skp = sym_is_skip(in_sym);
  assign is_com = sym_is_comma(in_sym);
  assign wfill  = wptr_q - rptr_s;
  assign full   = (wfill == PW'(DEPTH));
  assign drop   = in_vld && is_skp && in_os_q && !del_done_q && (wfill >= PW'(HI_LVL));
  assign push   = in_vld && !drop && !full;

  always_comb begin
    wptr_d     = wptr_q + PW'(push);
    ovf_d      = ovf_q | (in_vld && !drop && full);
    in_os_d    = in_os_q;
    del_done_d = del_done_q;
    if (in_vld) begin
      in_os_d    = is_com || (is_skp && in_os_q);
      del_done_d = is_com ? 1'b0 : (del_done_q || drop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q     <= '0;
      ovf_q      <= 1'b0;
      in_os_q    <= 1'b0;
      del_done_q <= 1'b0;
    end else begin
      wptr_q     <= wptr_d;
      ovf_q      <= ovf_d;
      in_os_q    <= in_os_d;
      del_done_q <= del_done_d;
    end
  end

  assign wptr  = wptr_q;
  assign we    = push;
  assign waddr = wptr_q[AW-1:0];
  assign ovf   = ovf_q;

  p_fill_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wfill <= PW'(DEPTH));
  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
  p_drop_only_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !we && !full) |-> sym_is_skip(in_sym));
  p_wptr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wptr_q != $past(wptr_q)) |-> (wptr_q == $past(wptr_q) + PW'(1)));
endmodule

// File: rtl/rxeb_rd_ctl.sv
module rxeb_rd_ctl
  import rxeb_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int LO_LVL    = 3,
  parameter int START_LVL = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(DEPTH):0]   wptr_s,
  input  logic [SYM_W-1:0]         head_sym,
  output logic [$clog2(DEPTH)-1:0] raddr,
  output logic [$clog2(DEPTH):0]   rptr,
  output logic [SYM_W-1:0]         out_sym,
  output logic                     out_vld,
  output logic                     unf
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0]    rptr_q, rptr_d, rfill;
  logic [SYM_W-1:0] out_sym_q, out_sym_d;
  logic             out_vld_q, out_vld_d, started_q, started_d, unf_q, unf_d;
  logic             in_os_q, in_os_d, ins_done_q, ins_done_d;
  logic             empty, take, ins, adv;

  assign rfill = wptr_s - rptr_q;
  assign empty = (rfill == '0);
  assign take  = started_q && !empty;
  assign ins   = take && sym_is_skip(head_sym) && in_os_q && !ins_done_q &&
                 (rfill < PW'(LO_LVL));
  assign adv   = take && !ins;

  always_comb begin
    rptr_d     = rptr_q + PW'(adv);
    started_d  = started_q || (rfill >= PW'(START_LVL));
    out_vld_d  = take;
    out_sym_d  = take ? head_sym : out_sym_q;
    unf_d      = unf_q || (started_q && empty);
    in_os_d    = in_os_q;
    ins_done_d = ins_done_q;
    if (take) begin
      in_os_d    = sym_is_comma(head_sym) || (sym_is_skip(head_sym) && in_os_q);
      ins_done_d = sym_is_comma(head_sym) ? 1'b0 : (ins_done_q || ins);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q     <= '0;
      started_q  <= 1'b0;
      out_vld_q  <= 1'b0;
      out_sym_q  <= '0;
      unf_q      <= 1'b0;
      in_os_q    <= 1'b0;
      ins_done_q <= 1'b0;
    end else begin
      rptr_q     <= rptr_d;
      started_q  <= started_d;
      out_vld_q  <= out_vld_d;
      out_sym_q  <= out_sym_d;
      unf_q      <= unf_d;
      in_os_q    <= in_os_d;
      ins_done_q <= ins_done_d;
    end
  end

  assign raddr   = rptr_q[AW-1:0];
  assign rptr    = rptr_q;
  assign out_sym = out_sym_q;
  assign out_vld = out_vld_q;
  assign unf     = unf_q;

  p_unf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    unf_q |=> unf_q);
  p_silent_before_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !started_q |=> !out_vld_q);
  p_repeat_is_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld_q && $past(out_vld_q) && (rptr_q == $past(rptr_q))) |-> sym_is_skip(out_sym_q));
  p_rfill_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rfill <= PW'(DEPTH));
endmodule

// File: rtl/rx_elastic_buf.sv
module rx_elastic_buf
  import rxeb_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             wclk,
  input  logic             wrst_n,
  input  logic             wr_valid,
  input  logic [SYM_W-1:0] wr_sym,
  input  logic             rclk,
  input  logic             rrst_n,
  output logic [SYM_W-1:0] rd_sym,
  output logic             rd_valid,
  output logic             ovf_err,
  output logic             unf_err
);
  localparam int AW        = $clog2(DEPTH);
  localparam int PW        = AW + 1;
  localparam int LAG       = SYNC_STAGES + 1;
  localparam int START_LVL = DEPTH / 2 - LAG;
  localparam int HI_LVL    = DEPTH / 2 + LAG + 2;
  localparam int LO_LVL    = DEPTH / 2 - LAG - 2;

  logic             w_rst_n, r_rst_n, we;
  logic [AW-1:0]    waddr, raddr;
  logic [PW-1:0]    wptr, rptr, wptr_s, rptr_s;
  logic [SYM_W-1:0] head_sym;
  logic [SYM_W-1:0] mem [DEPTH];

  rxeb_rst_sync u_wrst (.clk(wclk), .arst_n(wrst_n), .srst_n(w_rst_n));
  rxeb_rst_sync u_rrst (.clk(rclk), .arst_n(rrst_n), .srst_n(r_rst_n));

  rxeb_wr_ctl #(.DEPTH(DEPTH), .HI_LVL(HI_LVL)) u_wr (
    .clk(wclk), .rst_n(w_rst_n), .in_vld(wr_valid), .in_sym(wr_sym),
    .rptr_s(rptr_s), .wptr(wptr), .we(we), .waddr(waddr), .ovf(ovf_err)
  );

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wr_sym;
  end

  assign head_sym = mem[raddr];

  rxeb_gray_sync #(.PW(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .src_clk(wclk), .src_rst_n(w_rst_n), .src_bin(wptr),
    .dst_clk(rclk), .dst_rst_n(r_rst_n), .dst_bin(wptr_s)
  );

  rxeb_gray_sync #(.PW(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .src_clk(rclk), .src_rst_n(r_rst_n), .src_bin(rptr),
    .dst_clk(wclk), .dst_rst_n(w_rst_n), .dst_bin(rptr_s)
  );

  rxeb_rd_ctl #(.DEPTH(DEPTH), .LO_LVL(LO_LVL), .START_LVL(START_LVL)) u_rd (
    .clk(rclk), .rst_n(r_rst_n), .wptr_s(wptr_s), .head_sym(head_sym),
    .raddr(raddr), .rptr(rptr), .out_sym(rd_sym), .out_vld(rd_valid), .unf(unf_err)
  );
endmodule

// File: tb/rx_elastic_buf_tb.sv
`timescale 1ns/1ps
module rx_elastic_buf_tb;
  localparam logic [9:0] C_N = 10'b0011111010, C_P = 10'b1100000101;
  localparam logic [9:0] S_N = 10'b0011110100, S_P = 10'b1100001011;

  real        wper = 5.0, rper = 5.0;
  logic       wclk = 0, rclk = 0, rclk_en = 1, rst_n = 0;
  logic       wr_valid = 0;
  logic [9:0] wr_sym = '0;
  logic [9:0] rd_sym;
  logic       rd_valid, ovf_err, unf_err;
  int         total = 0, bad = 0, dcnt = 0;
  bit         seen_vld = 0;
  logic [9:0] in_q[$];
  logic [9:0] out_q[$];

  rx_elastic_buf u_dut (
    .wclk(wclk), .wrst_n(rst_n), .wr_valid(wr_valid), .wr_sym(wr_sym),
    .rclk(rclk), .rrst_n(rst_n), .rd_sym(rd_sym), .rd_valid(rd_valid),
    .ovf_err(ovf_err), .unf_err(unf_err)
  );

  always #(wper / 2.0) wclk = ~wclk;
  always begin
    #(rper / 2.0);
    if (rclk_en) rclk = ~rclk;
  end

  always @(negedge rclk) begin
    if (rst_n && rd_valid) begin
      out_q.push_back(rd_sym);
      seen_vld = 1;
    end
  end

  function automatic bit is_skp(input logic [9:0] s);
    return (s == S_N) || (s == S_P);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [9:0] s);
    @(negedge wclk);
    wr_valid = 1;
    wr_sym   = s;
    in_q.push_back(s);
  endtask

  task automatic idle();
    @(negedge wclk);
    wr_valid = 0;
  endtask

  task automatic send_data();
    send(10'h100 | 10'(dcnt & 8'hFF));
    dcnt++;
  endtask

  task automatic do_reset();
    rst_n = 0;
    wr_valid = 0;
    #20;
    rst_n = 1;
    repeat (6) @(negedge wclk);
    in_q.delete();
    out_q.delete();
    seen_vld = 0;
  endtask

  task automatic stream(input int n_os);
    for (int k = 0; k < n_os; k++) begin
      for (int d = 0; d < 16; d++) send_data();
      send(k[0] ? C_P : C_N);
      for (int j = 0; j < 3; j++) send(k[0] ? S_P : S_N);
    end
  endtask

  // Checks the order of non-skip symbols (R1) and tallies skip-run changes per set
  task automatic analyze(input string tag, output int dels, output int ins,
                         output int del_p, output int ins_p, output int odd);
    logic [9:0] a[$];
    logic [9:0] b[$];
    int mism = -1;
    dels = 0; ins = 0; del_p = 0; ins_p = 0; odd = 0;
    foreach (in_q[i])  if (!is_skp(in_q[i]))  a.push_back(in_q[i]);
    foreach (out_q[i]) if (!is_skp(out_q[i])) b.push_back(out_q[i]);
    foreach (b[i]) if (mism < 0 && (i >= a.size() || b[i] != a[i])) mism = i;
    chk(mism < 0, {"R1 order ", tag}, mism, -1);
    chk(b.size() + 24 > a.size(), {"R1 count ", tag}, b.size(), a.size());
    for (int i = 0; i < out_q.size(); i++) begin
      if (out_q[i] == C_N || out_q[i] == C_P) begin
        int n = 0;
        while (i + 1 + n < out_q.size() && is_skp(out_q[i+1+n])) n++;
        if (i + 1 + n < out_q.size()) begin
          if (n == 2) begin dels++; if (out_q[i] == C_P) del_p++; end
          else if (n == 4) begin ins++; if (out_q[i] == C_P) ins_p++; end
          else if (n != 3) odd++;
        end
      end
    end
  endtask

  initial begin
    #500000;
    total++;
    bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int dl, ins, dp, ip, odd;
    #3;
    chk(rd_valid === 1'b0 && ovf_err === 1'b0 && unf_err === 1'b0, "R2 in reset", rd_valid, 0);
    do_reset();
    chk(rd_valid == 0 && ovf_err == 0 && unf_err == 0, "R2 after reset",
        {ovf_err, unf_err, rd_valid}, 0);

    // R3 start level and R8 underflow
    for (int i = 0; i < 4; i++) send_data();
    idle();
    repeat (30) @(negedge rclk);
    chk(seen_vld == 0, "R3 silent at 4", seen_vld, 0);
    send_data();
    idle();
    repeat (30) @(negedge rclk);
    chk(out_q.size() == 5, "R3 output after 5", out_q.size(), 5);
    foreach (out_q[i]) chk(out_q[i] == in_q[i], "R1 start data", out_q[i], in_q[i]);
    chk(unf_err == 1, "R8 underflow set", unf_err, 1);
    chk(ovf_err == 0, "R7 no overflow", ovf_err, 0);
    repeat (20) @(negedge rclk);
    chk(unf_err == 1 && rd_valid == 0, "R8 sticky and silent", unf_err, 1);
    chk(out_q.size() == 5, "R8 nothing extra", out_q.size(), 5);
    do_reset();
    chk(unf_err == 0 && ovf_err == 0 && rd_valid == 0, "R2 clear after reset", unf_err, 0);

    // R7 overflow with the read clock stopped
    rclk_en = 0;
    do_reset();
    for (int i = 0; i < 16; i++) send_data();
    idle();
    chk(ovf_err == 0, "R7 no flag at 16", ovf_err, 0);
    send_data();
    idle();
    chk(ovf_err == 1, "R7 flag on 17th", ovf_err, 1);
    rclk_en = 1;
    repeat (60) @(negedge wclk);
    chk(out_q.size() == 16, "R7 17th dropped", out_q.size(), 16);
    for (int i = 0; i < 16 && i < out_q.size(); i++)
      chk(out_q[i] == in_q[i], "R7 kept data", out_q[i], in_q[i]);
    chk(ovf_err == 1, "R7 sticky", ovf_err, 1);

    // R6 equal clocks
    wper = 5.0; rper = 5.0;
    do_reset();
    stream(20);
    chk(ovf_err == 0 && unf_err == 0, "R6 no errors", {ovf_err, unf_err}, 0);
    idle();
    analyze("equal", dl, ins, dp, ip, odd);
    chk(dl == 0 && ins == 0, "R6 no change", dl + ins, 0);
    chk(odd == 0, "R6 runs intact", odd, 0);

    // R4 fast write clock
    wper = 4.9; rper = 5.0;
    do_reset();
    stream(30);
    chk(ovf_err == 0 && unf_err == 0, "R4 no errors", {ovf_err, unf_err}, 0);
    idle();
    analyze("fast", dl, ins, dp, ip, odd);
    chk(dl >= 5 && ins == 0, "R4 deletions", dl, 5);
    chk(dp > 0 && dl - dp > 0, "R9 deletions both forms", dp, 1);
    chk(odd == 0, "R4 at most one per set", odd, 0);

    // R5 slow write clock
    wper = 5.1; rper = 5.0;
    do_reset();
    stream(30);
    chk(ovf_err == 0 && unf_err == 0, "R5 no errors", {ovf_err, unf_err}, 0);
    idle();
    analyze("slow", dl, ins, dp, ip, odd);
    chk(ins >= 5 && dl == 0, "R5 insertions", ins, 5);
    chk(ip > 0 && ins - ip > 0, "R9 insertions both forms", ip, 1);
    chk(odd == 0, "R5 at most one per set", odd, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule